// File: doc/BRIEF.md
# Descriptor Chain Walker

This block runs one DMA channel from a chain of buffer descriptors held in a word-addressed memory. A start pulse supplies the word address of the first descriptor. The walker then reads each descriptor and confirms that the host has handed it over. It streams the described buffer out as a sequence of beats on a valid/ready port, writes the updated header word back, and then either moves to the next descriptor, returns to the first one, or stops.

Each descriptor is two or three words long. The first word is the header: byte count, status byte and command byte. The second word is the word address of the data buffer. An optional third word is reserved and is skipped. Status bits decide the following, one descriptor at a time: ownership, chaining, the return to the start of the ring, the interrupt request and the descriptor length. Command bits choose the transfer unit and optional byte reversal. All addresses in this block are word addresses. One memory word is fetched per output beat, and the chosen unit is taken from its low bytes.

Top module: `desc_walker`

## Requirements
- R1: An accepted start fetches the header word at `base_addr`, with the byte count in bits [15:0], status in bits [23:16] and command in bits [31:24], and then the buffer word address from the following word.
- R2: If header bit 16 (owned) is clear, the walker stops with no output beat, no memory write and no interrupt.
- R3: After finishing a descriptor, the walker writes the header back to the same address with bit 16 cleared, the count and command unchanged, and bit 20 set only if a fault occurred.
- R4: Command bits [25:24] give the unit: 0 = 4 bytes, 1 = 1 byte, 2 = 2 bytes, 3 = 3 bytes. Each beat reads the next buffer word and presents its low unit bytes, zero-extended, on `out_data`. A descriptor produces ceil(count / unit) beats, and `out_last` marks the final beat.
- R5: When command bit 31 is set, the byte order within each unit is reversed.
- R6: If header bit 18 (continue) is set and no fault occurred, the next descriptor is fetched. Otherwise the walker stops.
- R7: If header bit 17 (wrap) is set, the next descriptor address is the base address of the run.
- R8: If bit 17 is clear, the next descriptor address is the current address plus 3 when header bit 23 (long form) is set, and plus 2 otherwise.
- R9: When a descriptor with header bit 19 set is written back without a fault, `irq` pulses for exactly one cycle, in the cycle after the write.
- R10: If `mem_err` is high with the returned buffer word, that word produces no beat. The header is written back with bit 20 set, `err_flag` is set and the walker stops with no interrupt. `err_flag` is cleared by the next accepted start.
- R11: A byte count of zero produces no beats. The header is written back at once and the chaining rules then apply.
- R12: `busy` is high from the cycle after an accepted start until the walker stops. A start received while busy is ignored.
- R13: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and `out_last` hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse, taken only when idle |
| base_addr | input | AW | Word address of the first descriptor |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Write enable for the access |
| mem_addr | output | AW | Word address of the access |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid the cycle after a read request |
| mem_err | input | 1 | Fault flag returned alongside read data |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Sink accepts the beat |
| out_data | output | 32 | Beat data |
| out_last | output | 1 | Final beat of the current descriptor |
| irq | output | 1 | Completion interrupt pulse |
| err_flag | output | 1 | Last descriptor ended with a fault |
| busy | output | 1 | Channel running |

## Verification
The bench builds the block with AW = 8, which gives a 256-word memory. With that size, descriptor areas, buffers, a two-entry ring and a long-form descriptor can all sit side by side. Address arithmetic for the next descriptor and the wrap back to the base can then be followed word by word against a full copy of the expected memory. A pseudo-random ready pattern brings stalls on every unit width and with byte reversal within reach. A placeable fault address brings the error path mid-buffer within reach, with the following descriptor left untouched.

// File: rtl/desc_walker_pkg.sv
package desc_walker_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_HDR, ST_ADR, ST_CHK, ST_DREQ, ST_DCAP, ST_OUT, ST_WB
  } dw_state_e;

  localparam int HB_OWN  = 16;
  localparam int HB_WRAP = 17;
  localparam int HB_CONT = 18;
  localparam int HB_IRQ  = 19;
  localparam int HB_ERR  = 20;
  localparam int HB_LONG = 23;
  localparam int HB_SWAP = 31;

  function automatic logic [2:0] unit_bytes(input logic [1:0] code);
    return (code == 2'd0) ? 3'd4 : {1'b0, code};
  endfunction

endpackage

// File: rtl/desc_walker_fmt.sv
module desc_walker_fmt
  import desc_walker_pkg::*;
#(
  parameter int NB = 4
) (
  input  logic [8*NB-1:0] word_i,
  input  logic [1:0]      unit_i,
  input  logic            swap_i,
  output logic [8*NB-1:0] word_o
);
  logic [2:0] ub;
  assign ub = unit_bytes(unit_i);

  for (genvar i = 0; i < NB; i++) begin : g_lane
    logic [2:0] src;
    assign src = swap_i ? 3'(ub - 3'd1 - 3'(i)) : 3'(i);
    assign word_o[8*i +: 8] = (3'(i) < ub) ? word_i[8*src[1:0] +: 8] : 8'h00;
  end
endmodule

// File: rtl/desc_walker_nxt.sv
module desc_walker_nxt
  import desc_walker_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic [31:0]   hdr_i,
  input  logic [AW-1:0] ptr_i,
  input  logic [AW-1:0] base_i,
  input  logic          fault_i,
  output logic [31:0]   wb_word_o,
  output logic [AW-1:0] next_ptr_o,
  output logic          go_on_o,
  output logic          irq_req_o
);
  localparam logic [AW-1:0] STEP_SHORT = AW'(2);
  localparam logic [AW-1:0] STEP_LONG  = AW'(3);

  always_comb begin
    wb_word_o         = hdr_i;
    wb_word_o[HB_OWN] = 1'b0;
    wb_word_o[HB_ERR] = hdr_i[HB_ERR] | fault_i;
  end

  assign next_ptr_o = hdr_i[HB_WRAP] ? base_i
                    : ptr_i + (hdr_i[HB_LONG] ? STEP_LONG : STEP_SHORT);
  assign go_on_o    = hdr_i[HB_CONT] & ~fault_i;
  assign irq_req_o  = hdr_i[HB_IRQ] & ~fault_i;
endmodule

// File: rtl/desc_walker_ctl.sv
module desc_walker_ctl
  import desc_walker_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] base_addr,
  input  logic [31:0]   mem_rdata,
  input  logic          mem_err,
  input  logic          out_ready,
  input  logic [31:0]   fmt_word,
  input  logic [31:0]   wb_word,
  input  logic [AW-1:0] next_ptr,
  input  logic          go_on,
  input  logic          irq_req,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  output logic          out_valid,
  output logic [31:0]   out_data,
  output logic          out_last,
  output logic          irq,
  output logic          err_flag,
  output logic          busy,
  output logic [31:0]   hdr,
  output logic [AW-1:0] ptr,
  output logic [AW-1:0] base,
  output logic          fault
);
  dw_state_e     state_q, state_d;
  logic [AW-1:0] ptr_q, ptr_d, base_q, base_d, buf_q, buf_d;
  logic [31:0]   hdr_q, hdr_d, data_q, data_d;
  logic [CW-1:0] rem_q, rem_d;
  logic          last_q, last_d, fault_q, fault_d, err_q, err_d, irq_q, irq_d;
  logic          data_en;
  logic [CW-1:0] unit_w;

  assign unit_w = CW'(unit_bytes(hdr_q[25:24]));

  always_comb begin
    state_d = state_q;  ptr_d  = ptr_q;  base_d = base_q; buf_d = buf_q;
    hdr_d   = hdr_q;    rem_d  = rem_q;  data_d = data_q; last_d = last_q;
    fault_d = fault_q;  err_d  = err_q;  irq_d  = 1'b0;   data_en = 1'b0;
    mem_req = 1'b0;     mem_we = 1'b0;   mem_addr = ptr_q; mem_wdata = '0;
    unique case (state_q)
      ST_IDLE: if (start) begin
        ptr_d = base_addr; base_d = base_addr; err_d = 1'b0; state_d = ST_HDR;
      end
      ST_HDR: begin
        mem_req = 1'b1; state_d = ST_ADR;
      end
      ST_ADR: begin
        mem_req = 1'b1; mem_addr = ptr_q + AW'(1);
        hdr_d = mem_rdata; state_d = ST_CHK;
      end
      ST_CHK: begin
        buf_d = mem_rdata[AW-1:0]; rem_d = hdr_q[CW-1:0]; fault_d = 1'b0;
        if (!hdr_q[HB_OWN])             state_d = ST_IDLE;
        else if (hdr_q[CW-1:0] == '0)   state_d = ST_WB;
        else                            state_d = ST_DREQ;
      end
      ST_DREQ: begin
        mem_req = 1'b1; mem_addr = buf_q; state_d = ST_DCAP;
      end
      ST_DCAP: begin
        if (mem_err) begin
          fault_d = 1'b1; state_d = ST_WB;
        end else begin
          data_en = 1'b1; data_d = fmt_word;
          last_d  = (rem_q <= unit_w); state_d = ST_OUT;
        end
      end
      ST_OUT: if (out_ready) begin
        if (last_q) state_d = ST_WB;
        else begin
          rem_d = rem_q - unit_w; buf_d = buf_q + AW'(1); state_d = ST_DREQ;
        end
      end
      ST_WB: begin
        mem_req = 1'b1; mem_we = 1'b1; mem_wdata = wb_word;
        irq_d = irq_req; err_d = fault_q;
        if (go_on) begin ptr_d = next_ptr; state_d = ST_HDR; end
        else state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE; ptr_q <= '0; base_q <= '0; buf_q <= '0;
      hdr_q <= '0; rem_q <= '0; data_q <= '0; last_q <= 1'b0;
      fault_q <= 1'b0; err_q <= 1'b0; irq_q <= 1'b0;
    end else begin
      state_q <= state_d; ptr_q <= ptr_d; base_q <= base_d; buf_q <= buf_d;
      hdr_q <= hdr_d; rem_q <= rem_d; fault_q <= fault_d;
      err_q <= err_d; irq_q <= irq_d;
      if (data_en) begin
        data_q <= data_d; last_q <= last_d;
      end
    end
  end

  assign out_valid = (state_q == ST_OUT);
  assign out_data  = data_q;
  assign out_last  = last_q;
  assign irq       = irq_q;
  assign err_flag  = err_q;
  assign busy      = (state_q != ST_IDLE);
  assign hdr       = hdr_q;
  assign ptr       = ptr_q;
  assign base      = base_q;
  assign fault     = fault_q;
endmodule

// File: rtl/desc_walker.sv
module desc_walker
  import desc_walker_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] base_addr,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic [31:0]   mem_rdata,
  input  logic          mem_err,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [31:0]   out_data,
  output logic          out_last,
  output logic          irq,
  output logic          err_flag,
  output logic          busy
);
  localparam int CW = 16;

  logic [1:0]    rsync_q;
  logic          rst_int_n;
  logic [31:0]   hdr, fmt_word, wb_word;
  logic [AW-1:0] ptr, base, next_ptr;
  logic          fault, go_on, irq_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_int_n = rsync_q[1];

  desc_walker_fmt #(.NB(4)) u_fmt (
    .word_i (mem_rdata),
    .unit_i (hdr[25:24]),
    .swap_i (hdr[HB_SWAP]),
    .word_o (fmt_word)
  );

  desc_walker_nxt #(.AW(AW)) u_nxt (
    .hdr_i      (hdr),
    .ptr_i      (ptr),
    .base_i     (base),
    .fault_i    (fault),
    .wb_word_o  (wb_word),
    .next_ptr_o (next_ptr),
    .go_on_o    (go_on),
    .irq_req_o  (irq_req)
  );

  desc_walker_ctl #(.AW(AW), .CW(CW)) u_ctl (
    .clk, .rst_n(rst_int_n), .start, .base_addr,
    .mem_rdata, .mem_err, .out_ready,
    .fmt_word, .wb_word, .next_ptr, .go_on, .irq_req,
    .mem_req, .mem_we, .mem_addr, .mem_wdata,
    .out_valid, .out_data, .out_last, .irq, .err_flag, .busy,
    .hdr, .ptr, .base, .fault
  );
endmodule

// File: rtl/desc_walker_chk.sv
module desc_walker_chk #(
  parameter int AW = 16
) (
  input logic        clk,
  input logic        rst_n,
  input logic        mem_we,
  input logic [31:0] mem_wdata,
  input logic        out_valid,
  input logic        out_ready,
  input logic [31:0] out_data,
  input logic        out_last,
  input logic        irq,
  input logic        err_flag,
  input logic        busy
);
  p_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last));

  p_own_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> !mem_wdata[16]);

  p_irq_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(mem_we) && $past(mem_wdata[19]) && !$past(mem_wdata[20]));

  p_irq_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  p_err_src_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_flag) |-> $past(mem_we) && $past(mem_wdata[20]));

  p_active_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid || mem_we) |-> busy);
endmodule

bind desc_walker desc_walker_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_we(mem_we), .mem_wdata(mem_wdata),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
  .out_last(out_last), .irq(irq), .err_flag(err_flag), .busy(busy)
);

// File: tb/desc_walker_tb.sv
`timescale 1ns/1ps
module desc_walker_tb;
  localparam int AW = 8;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst_n, start, mem_req, mem_we, mem_err;
  logic [AW-1:0] base_addr, mem_addr;
  logic [31:0]   mem_wdata, mem_rdata, out_data;
  logic          out_valid, out_ready, out_last, irq, err_flag, busy;

  desc_walker #(.AW(AW)) u_dut (
    .clk, .rst_n, .start, .base_addr, .mem_req, .mem_we, .mem_addr,
    .mem_wdata, .mem_rdata, .mem_err, .out_valid, .out_ready, .out_data,
    .out_last, .irq, .err_flag, .busy
  );

  logic [31:0] mem     [0:255];
  logic [31:0] exp_mem [0:255];
  logic [8:0]  fault_addr = 9'h100;
  logic [7:0]  lfsr = 8'h5b;
  logic [32:0] exp_q[$];
  int checks = 0, errors = 0, irq_cnt = 0, exp_irq = 0, cyc = 0;
  logic exp_err;
  string cur_tag = "R4";
  logic stall_p = 1'b0;
  logic [32:0] held;

  always @(posedge clk) begin
    if (mem_req) begin
      if (mem_we) mem[mem_addr] <= mem_wdata;
      else begin
        mem_rdata <= mem[mem_addr];
        mem_err   <= ({1'b0, mem_addr} == fault_addr);
      end
    end
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
  end
  assign out_ready = lfsr[0] | lfsr[1];

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d expected below 100000 cycles", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // Beat-by-beat comparison against the behavioural model queue
  always @(negedge clk) begin
    if (rst_n) begin
      if (stall_p)
        chk(out_valid && {out_last, out_data} == held, "R13", "stalled beat",
            out_data, held[31:0]);
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) chk(1'b0, "R4", "unexpected beat", out_data, 32'h0);
        else begin
          logic [32:0] e;
          e = exp_q.pop_front();
          chk({out_last, out_data} == e, cur_tag, "beat", {out_last, out_data[30:0]},
              {e[32], e[30:0]});
        end
      end
      if (irq) irq_cnt++;
      stall_p <= out_valid && !out_ready;
      held    <= {out_last, out_data};
    end
  end

  function automatic logic [31:0] shape(input logic [31:0] w, input logic [7:0] cmd);
    int u;
    logic [31:0] r;
    u = (cmd[1:0] == 2'd0) ? 4 : int'(cmd[1:0]);
    r = '0;
    for (int b = 0; b < u; b++) r[8*b +: 8] = w[8*(cmd[7] ? (u - 1 - b) : b) +: 8];
    return r;
  endfunction

  task automatic walk(input logic [7:0] base);
    logic [7:0] p;
    p = base; exp_irq = 0; exp_err = 1'b0;
    for (int n = 0; n < 64; n++) begin
      logic [31:0] w0;
      logic [7:0] a, st, cmd;
      int rem, u;
      bit err;
      w0 = exp_mem[p];
      if (!w0[16]) break;
      st = w0[23:16]; cmd = w0[31:24]; rem = int'(w0[15:0]);
      u = (cmd[1:0] == 2'd0) ? 4 : int'(cmd[1:0]);
      a = exp_mem[p + 8'd1][7:0]; err = 1'b0;
      while (rem > 0) begin
        if ({1'b0, a} == fault_addr) begin err = 1'b1; break; end
        exp_q.push_back({rem <= u, shape(exp_mem[a], cmd)});
        rem = (rem > u) ? rem - u : 0;
        a++;
      end
      exp_mem[p] = {cmd, (st & 8'hFE) | (err ? 8'h10 : 8'h00), w0[15:0]};
      if (err) begin exp_err = 1'b1; break; end
      if (st[3]) exp_irq++;
      if (!st[2]) break;
      p = st[1] ? base : p + (st[7] ? 8'd3 : 8'd2);
    end
  endtask

  task automatic run(input logic [7:0] base, input string tag, input bit spur,
                     input logic [7:0] spur_base);
    int bad;
    for (int i = 0; i < 256; i++) exp_mem[i] = mem[i];
    walk(base);
    irq_cnt = 0; cur_tag = tag;
    @(negedge clk); start = 1'b1; base_addr = base;
    @(negedge clk); start = 1'b0;
    chk(busy, "R12", "busy after start", {31'b0, busy}, 32'h1);
    if (spur) begin
      base_addr = spur_base; start = 1'b1;
      @(negedge clk); start = 1'b0;
    end
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
    chk(exp_q.size() == 0, "R4", "beats left over", exp_q.size(), 32'h0);
    exp_q.delete();
    chk(irq_cnt == exp_irq, "R9", "irq count", irq_cnt, exp_irq);
    chk(err_flag == exp_err, "R10", "err_flag", {31'b0, err_flag}, {31'b0, exp_err});
    bad = 0;
    for (int i = 0; i < 256; i++) if (mem[i] !== exp_mem[i]) bad++;
    chk(bad == 0, "R3", {tag, " memory image"}, bad, 32'h0);
  endtask

  function automatic logic [31:0] hw(input int cnt, input logic [7:0] st,
                                     input logic [7:0] cmd);
    return {cmd, st, 16'(cnt)};
  endfunction

  initial begin
    rst_n = 1'b0; start = 1'b0; base_addr = '0;
    for (int i = 0; i < 256; i++) mem[i] = '0;
    for (int i = 128; i < 256; i++)
      mem[i] = {8'(i) ^ 8'h5a, 8'(i) + 8'd1, 8'(i) + 8'd7, 8'(i) ^ 8'hc3};
    repeat (5) @(negedge clk);
    chk(!busy && !out_valid && !irq && !err_flag && !mem_req, "R12", "reset state",
        {27'b0, busy, out_valid, irq, err_flag, mem_req}, 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 R4 R9 R12: single word-wide descriptor, spurious start ignored
    mem[8'h10] = hw(8, 8'h09, 8'h00);  mem[8'h11] = 32'h80;
    mem[8'h30] = hw(4, 8'h09, 8'h00);  mem[8'h31] = 32'h90;
    run(8'h10, "R1", 1'b1, 8'h30);

    // R5 R6 R8: byte, long-form swapped halfword, swapped 24-bit
    mem[8'h20] = hw(3, 8'h05, 8'h01);  mem[8'h21] = 32'h84;
    mem[8'h22] = hw(5, 8'h85, 8'h82);  mem[8'h23] = 32'h88; mem[8'h24] = 32'hdead;
    mem[8'h25] = hw(6, 8'h09, 8'h83);  mem[8'h26] = 32'h8c;
    run(8'h20, "R5", 1'b0, 8'h0);
    chk(mem[8'h25][16] == 1'b0, "R8", "long-form step reached next", mem[8'h25], 32'h0);

    // R7: two-entry ring, stops when it comes back to a released entry
    mem[8'h40] = hw(4, 8'h05, 8'h00);  mem[8'h41] = 32'h90;
    mem[8'h42] = hw(2, 8'h0f, 8'h02);  mem[8'h43] = 32'h91;
    run(8'h40, "R7", 1'b0, 8'h0);

    // R2: first descriptor not owned
    run(8'h40, "R2", 1'b0, 8'h0);
    chk(irq_cnt == 0, "R2", "no irq when not owned", irq_cnt, 32'h0);

    // R11: zero count then a normal descriptor
    mem[8'h50] = hw(0, 8'h0d, 8'h00);  mem[8'h51] = 32'h0;
    mem[8'h52] = hw(4, 8'h01, 8'h00);  mem[8'h53] = 32'h92;
    run(8'h50, "R11", 1'b0, 8'h0);

    // R10: fault on second buffer word stops the chain
    mem[8'h60] = hw(12, 8'h0d, 8'h00); mem[8'h61] = 32'h94;
    mem[8'h62] = hw(4, 8'h01, 8'h00);  mem[8'h63] = 32'h98;
    fault_addr = 9'h095;
    run(8'h60, "R10", 1'b0, 8'h0);
    chk(mem[8'h60][20] == 1'b1, "R10", "error bit written", mem[8'h60], 32'h0);
    fault_addr = 9'h100;

    // R10 R6: new start clears err_flag; stops where continue is clear
    run(8'h62, "R6", 1'b0, 8'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule